// File: doc/BRIEF.md
# Audio Sample Formatter Front End

This block sits between a processor-side write port and a serial audio line encoder. Software sets up a mode word, then writes 32-bit data words to a data address. Each word is turned into one or two 24-bit signed samples and queued in one of two per-channel FIFOs, channel A and channel B. The encoder pops samples from the head of each FIFO. Per-mode settings control how a sample is located inside a word: byte order, justification, valid-bit count and bytes per sample.

Samples leave the block MSB-aligned at bit 23. For fewer than 24 valid bits, the bits below the valid bits are zero. For more than 24 valid bits, the extra low bits are dropped. The channel that receives a word is set by one of three access modes: indexed, toggle or interleaved. A mono setting copies each sample into both channels. A status vector reports room, emptiness, fullness, chunk space and sticky underrun and overflow conditions. A control write empties both FIFOs and clears the sticky flags.

Top module: `aud_fmt_front`

## Requirements
- R1: After reset both FIFOs are empty. `status_o` reads ready=1, empty=1, full=0, chunk=1, underrun=0 and overflow=0. The status bit positions are ready 0, empty 1, full 2, chunk 3, underrun 4 and overflow 5.
- R2: Mode bit 2 selects the byte order of a data word: 0 is little-endian and 1 is big-endian. In big-endian mode the sample's bytes are reversed within its byte span before the sample is extracted.
- R3: Mode bit 3 selects justification: 0 is LSB-justified and 1 is MSB-justified within the byte span. Mode bits 13:8 give the valid-bit count (8, 16, 18, 20, 24 or 32; 0 or above 32 acts as 32). The output has the sample MSB at bit 23 and zeros below the valid bits.
- R4: Mode bits 29:28 hold the bytes per sample minus one (1 to 4 bytes). Word bytes outside the span have no effect on the sample.
- R5: Mode bit 1 = 0 (mono) pushes each sample into both channel FIFOs. Mode bit 1 = 1 selects dual-channel operation.
- R6: Mode bits 5:4 = 0 (indexed, also used for the value 3): a data write to address 2 goes to channel A and one to address 3 goes to channel B.
- R7: Mode bits 5:4 = 1 (toggle, dual): successive data writes alternate A, B, A and so on. The sequence starts at A after reset and after a FIFO clear.
- R8: Mode bits 5:4 = 2 (interleaved, dual): the low 16 bits of a word form the A sample and the high 16 bits form the B sample. Each half is treated as a 2-byte span with at most 16 valid bits.
- R9: Each FIFO returns samples in write order, one per pop. The head sample is visible on the output before the pop. Full (bit 2) is set when both FIFOs hold DEPTH entries. Ready (bit 0) is set when neither FIFO is full. Empty (bit 1) is set when both FIFOs are empty.
- R10: Chunk (bit 3) is set when each FIFO has at least as many free entries as the chunk field in mode bits 19:16.
- R11: A push into a full FIFO is dropped and sets the sticky overflow flag (bit 5).
- R12: A pop from an empty FIFO sets the sticky underrun flag (bit 4).
- R13: A write of bit 1 = 1 to address 0 (control) empties both FIFOs, clears the underrun and overflow flags and resets the toggle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 control, 1 mode, 2 data A, 3 data B |
| wr_data_i | input | 32 | Write data |
| pop_a_i | input | 1 | Encoder pop, channel A |
| pop_b_i | input | 1 | Encoder pop, channel B |
| smp_a_o | output | 24 | Head sample, channel A |
| smp_b_o | output | 24 | Head sample, channel B |
| status_o | output | 6 | Status flags |

## Verification
A wrong byte lane, shift amount or mask shows up on the head sample the cycle after the data write, as soon as that write reaches an empty FIFO. A stuck toggle pointer or a wrong channel steer shows up as a sample in the wrong channel, or as a channel that stays empty. A FIFO count that drifts from its pointers shows up first in the full, ready and chunk bits, and later as samples out of order or lost. Sticky flag faults show up one cycle after the causing write or pop, and again after a clear.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;
  typedef enum logic [1:0] {ACC_IDX = 2'd0, ACC_TGL = 2'd1, ACC_ILV = 2'd2, ACC_RSV = 2'd3} acc_e;

  typedef struct packed {
    logic       big;
    logic       msb;
    logic       dual;
    acc_e       acc;
    logic [5:0] vbits;
    logic [3:0] chunk;
    logic [1:0] bsz;
  } mode_t;

  localparam int ST_RDY  = 0;
  localparam int ST_EMP  = 1;
  localparam int ST_FULL = 2;
  localparam int ST_CHNK = 3;
  localparam int ST_UDR  = 4;
  localparam int ST_OVF  = 5;
endpackage

// File: rtl/aud_fmt_extract.sv
module aud_fmt_extract #(
  parameter int OW = 24
) (
  input  logic [31:0]   word_i,
  input  logic          big_i,
  input  logic          msb_i,
  input  logic          half_i,
  input  logic [5:0]    vbits_i,
  input  logic [1:0]    bsz_i,
  output logic [OW-1:0] smp_o
);
  logic [2:0]  nb;
  logic [5:0]  vb;
  logic [5:0]  sh;
  logic [31:0] sw, t, mask;

  always_comb begin
    nb = half_i ? 3'd2 : {1'b0, bsz_i} + 3'd1;
    vb = (vbits_i == 6'd0 || vbits_i > 6'd32) ? 6'd32 : vbits_i;
    if (half_i && vb > 6'd16) vb = 6'd16;
    sw = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(nb)) begin
        if (big_i) sw[i*8 +: 8] = word_i[(int'(nb) - 1 - i)*8 +: 8];
        else       sw[i*8 +: 8] = word_i[i*8 +: 8];
      end
    end
    // move sample MSB to bit 31, then clear bits below valid count
    sh   = msb_i ? (6'd32 - {nb, 3'b000}) : (6'd32 - vb);
    t    = sw << sh;
    mask = 32'hFFFF_FFFF << (6'd32 - vb);
    t    = t & mask;
    smp_o = t[31 -: OW];
  end
endmodule

// File: rtl/aud_fmt_fifo.sv
module aud_fmt_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] free_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign free_o  = CW'(DEPTH) - cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + AW'(1);
      if (do_pop)  rptr_q <= rptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/aud_fmt_front.sv
module aud_fmt_front
  import aud_fmt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OW    = 24,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic          pop_a_i,
  input  logic          pop_b_i,
  output logic [OW-1:0] smp_a_o,
  output logic [OW-1:0] smp_b_o,
  output logic [5:0]    status_o
);
  mode_t         mode_q;
  logic          tgl_q, udr_q, ovf_q;
  logic          clr, dwr, ilv, tgt_b, push_a, push_b;
  logic [OW-1:0] lane_smp [2];
  logic [OW-1:0] din_b;
  logic [1:0]    full, empty;
  logic [CW-1:0] free [2];

  assign clr = wr_en_i && (wr_addr_i == 2'd0) && wr_data_i[1];
  assign dwr = wr_en_i && wr_addr_i[1];
  assign ilv = (mode_q.acc == ACC_ILV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (wr_en_i && wr_addr_i == 2'd1) begin
      mode_q.dual  <= wr_data_i[1];
      mode_q.big   <= wr_data_i[2];
      mode_q.msb   <= wr_data_i[3];
      mode_q.acc   <= acc_e'(wr_data_i[5:4]);
      mode_q.vbits <= wr_data_i[13:8];
      mode_q.chunk <= wr_data_i[19:16];
      mode_q.bsz   <= wr_data_i[29:28];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    aud_fmt_extract #(.OW(OW)) u_ext (
      .word_i  (ilv ? {16'h0, wr_data_i[g*16 +: 16]} : wr_data_i),
      .big_i   (mode_q.big),
      .msb_i   (mode_q.msb),
      .half_i  (ilv),
      .vbits_i (mode_q.vbits),
      .bsz_i   (mode_q.bsz),
      .smp_o   (lane_smp[g])
    );
  end

  always_comb begin
    unique case (mode_q.acc)
      ACC_TGL: tgt_b = tgl_q;
      ACC_ILV: tgt_b = 1'b0;
      default: tgt_b = wr_addr_i[0];
    endcase
    push_a = dwr && (!mode_q.dual || ilv || !tgt_b);
    push_b = dwr && (!mode_q.dual || ilv || tgt_b);
    din_b  = (ilv && mode_q.dual) ? lane_smp[1] : lane_smp[0];
  end

  aud_fmt_fifo #(.W(OW), .DEPTH(DEPTH)) u_fifo_a (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(push_a), .pop_i(pop_a_i),
    .data_i(lane_smp[0]), .data_o(smp_a_o), .full_o(full[0]),
    .empty_o(empty[0]), .free_o(free[0])
  );

  aud_fmt_fifo #(.W(OW), .DEPTH(DEPTH)) u_fifo_b (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(push_b), .pop_i(pop_b_i),
    .data_i(din_b), .data_o(smp_b_o), .full_o(full[1]),
    .empty_o(empty[1]), .free_o(free[1])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      udr_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      tgl_q <= 1'b0;
      udr_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (dwr && mode_q.dual && mode_q.acc == ACC_TGL) tgl_q <= !tgl_q;
      if ((pop_a_i && empty[0]) || (pop_b_i && empty[1])) udr_q <= 1'b1;
      if ((push_a && full[0]) || (push_b && full[1]))     ovf_q <= 1'b1;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_RDY]  = !full[0] && !full[1];
    status_o[ST_EMP]  = empty[0] && empty[1];
    status_o[ST_FULL] = full[0] && full[1];
    status_o[ST_CHNK] = (32'(free[0]) >= 32'(mode_q.chunk)) &&
                        (32'(free[1]) >= 32'(mode_q.chunk));
    status_o[ST_UDR]  = udr_q;
    status_o[ST_OVF]  = ovf_q;
  end
endmodule

// File: rtl/aud_fmt_front_chk.sv
module aud_fmt_front_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        pop_a_i,
  input logic        pop_b_i,
  input logic [5:0]  status_o
);
  logic clr_w, data_w;
  assign clr_w  = wr_en_i && wr_addr_i == 2'd0 && wr_data_i[1];
  assign data_w = wr_en_i && wr_addr_i[1];

  // R9
  full_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> !status_o[0]);
  // R9
  empty_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[1] && status_o[2]));
  // R11
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_w && status_o[2] && !clr_w) |=> status_o[5]);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && !clr_w) |=> status_o[5]);
  // R12
  udr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pop_a_i || pop_b_i) && status_o[1] && !clr_w) |=> status_o[4]);
  // R13
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (status_o[1] && !status_o[4] && !status_o[5]));
endmodule

bind aud_fmt_front aud_fmt_front_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .pop_a_i, .pop_b_i, .status_o
);

// File: tb/aud_fmt_front_tb.sv
`timescale 1ns/1ps
module aud_fmt_front_tb;
  localparam int DEPTH = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pop_a = 1'b0, pop_b = 1'b0;
  logic [23:0] smp_a, smp_b;
  logic [5:0]  st;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aud_fmt_front #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pop_a_i(pop_a), .pop_b_i(pop_b),
    .smp_a_o(smp_a), .smp_b_o(smp_b), .status_o(st)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop(bit a, bit b);
    @(negedge clk); pop_a = a; pop_b = b;
    @(negedge clk); pop_a = 1'b0; pop_b = 1'b0;
  endtask

  function automatic logic [31:0] mw(bit big, bit msb, int vb, int nb, bit dual, int acc, int chunk);
    return (32'(nb - 1) << 28) | (32'(chunk) << 16) | (32'(vb) << 8) |
           (32'(acc) << 4) | (32'(msb) << 3) | (32'(big) << 2) | (32'(dual) << 1);
  endfunction

  function automatic logic [23:0] model(logic [31:0] w, bit big, bit msb, int vb, int nb);
    logic [63:0] f = 0, s, r;
    for (int i = 0; i < nb; i++) begin
      int src = big ? nb - 1 - i : i;
      f = f | (64'((w >> (src * 8)) & 32'hFF) << (8 * i));
    end
    s = msb ? (f >> (nb * 8 - vb)) : (f & ((64'd1 << vb) - 1));
    r = (vb >= 24) ? (s >> (vb - 24)) : (s << (24 - vb));
    return r[23:0];
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int vbl[6] = '{8, 16, 18, 20, 24, 32};
    int idx = 1;
    logic [31:0] w1, w2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(st), 32'b001011);

    // R2 R3 R4 R7 sweep over formats, toggle dual
    foreach (vbl[k]) begin
      for (int nb = 1; nb <= 4; nb++) begin
        if (nb * 8 < vbl[k]) continue;
        for (int bm = 0; bm < 4; bm++) begin
          wr(2'd1, mw(bm[0], bm[1], vbl[k], nb, 1'b1, 1, 0));
          w1 = 32'h9E37_79B9 * idx; w2 = 32'h85EB_CA6B * idx + 32'h1234;
          idx++;
          wr(2'd2, w1);
          wr(2'd3, w2);
          check("R2_R3_R4_R7 chA", 32'(smp_a), 32'(model(w1, bm[0], bm[1], vbl[k], nb)));
          check("R2_R3_R4_R7 chB", 32'(smp_b), 32'(model(w2, bm[0], bm[1], vbl[k], nb)));
          pop(1, 1);
        end
      end
    end
    check("R9 empty after sweep", 32'(st[1]), 1);

    // R4 bytes outside span ignored: 2 bytes, 16 valid, LSB, little
    wr(2'd1, mw(0, 0, 16, 2, 1'b1, 0, 0));
    wr(2'd2, 32'hFFFF_5A3C);
    check("R4 upper bytes ignored", 32'(smp_a), 32'h5A3C00);
    pop(1, 0);

    // R6 indexed: address 3 goes to B only
    wr(2'd3, 32'h0000_8001);
    check("R6 B head", 32'(smp_b), 32'h800100);
    pop(1, 0);
    check("R6 A untouched -> underrun", 32'(st[4]), 1);
    pop(0, 1);
    check("R6 B drained", 32'(st[1]), 1);
    wr(2'd0, 32'h2);
    check("R13 clear flags", 32'(st), 32'b001011);

    // R7 toggle restarts at A after clear
    wr(2'd1, mw(0, 0, 16, 2, 1'b1, 1, 0));
    wr(2'd2, 32'h0000_1111);
    wr(2'd0, 32'h2);
    wr(2'd3, 32'h0000_2222);
    check("R7 restart at A", 32'(smp_a), 32'h222200);
    pop(1, 0);
    check("R7 B got nothing", 32'(st[1]), 1);

    // R8 interleaved
    wr(2'd1, mw(0, 0, 16, 4, 1'b1, 2, 0));
    wr(2'd2, 32'hBEEF_1234);
    check("R8 A low half", 32'(smp_a), 32'h123400);
    check("R8 B high half", 32'(smp_b), 32'hBEEF00);
    pop(1, 1);
    wr(2'd1, mw(1, 0, 16, 4, 1'b1, 2, 0));
    wr(2'd2, 32'hBEEF_1234);
    check("R8 A swapped", 32'(smp_a), 32'h341200);
    check("R8 B swapped", 32'(smp_b), 32'hEFBE00);
    pop(1, 1);

    // R5 mono, R9 fill, R10 chunk, R11 overflow
    wr(2'd1, mw(0, 1, 20, 3, 1'b0, 0, 3));
    for (int i = 0; i < DEPTH; i++) begin
      wr(2'd2, 32'h0010_0000 * i + 32'h00AB_C000 + i);
      if (i == 4) check("R10 chunk at free 3", 32'(st[3]), 1);
      if (i == 5) check("R10 no chunk at free 2", 32'(st[3]), 0);
    end
    check("R9 full/ready", 32'(st[2:0]), 32'b100);
    check("R11 no ovf yet", 32'(st[5]), 0);
    wr(2'd2, 32'h00FF_FFFF);
    check("R11 overflow set", 32'(st[5]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      w1 = 32'h0010_0000 * i + 32'h00AB_C000 + i;
      check("R9 R5 order A", 32'(smp_a), 32'(model(w1, 0, 1, 20, 3)));
      check("R5 mono B", 32'(smp_b), 32'(model(w1, 0, 1, 20, 3)));
      pop(1, 1);
    end
    check("R9 empty", 32'(st[2:0]), 32'b011);
    check("R11 ovf sticky", 32'(st[5]), 1);
    check("R12 no udr yet", 32'(st[4]), 0);
    pop(0, 1);
    check("R12 underrun", 32'(st[4]), 1);
    wr(2'd0, 32'h2);
    check("R13 cleared", 32'(st[5:4]), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule